// File: doc/BRIEF.md
# Shared-Credit Add Traffic Shaper

This block keeps a byte-granular credit balance for one output link of a ring node. Every packet committed for transmission on that link is charged against the balance, whether it is transit traffic forwarded from the transit queue or traffic added by the local station. The balance is replenished every clock cycle by a fixed-point rate increment. The upstream logic sets this increment to the unreserved rate, which is the line rate less the bandwidth held for the top-priority class.

The block drives one gating flag, `add_en_o`. It gates only locally added low-priority traffic. Transit forwarding is never held back by this block, so transit can keep charging the balance and drive it below zero. The balance is signed and is capped at a ceiling. A packet's whole length is charged in the cycle it is handed to the stage buffer. The current integer balance is also exported.

Top module: `add_credit_shaper`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after release, `credit_o` equals the parameter `MAX_CREDIT` and `add_en_o` is 1.
- R2: The internal balance carries `FRAC_W` (8) fractional bits. Each clock edge adds `rate_i` to it, where `rate_i` is in bytes per cycle with 8 fractional bits. `credit_o` is the balance floored to whole bytes.
- R3: Whenever an update would take the balance above `MAX_CREDIT`, the balance is set to exactly `MAX_CREDIT`.
- R4: At the edge where `pkt_valid_i` is 1, the full `pkt_len_i` (in bytes) is subtracted from the balance.
- R5: `pkt_transit_i` has no effect on the charge. A transit packet and an added packet of the same length reduce the balance by the same amount.
- R6: When a charge and a replenish fall in the same cycle, the new balance is old + `rate_i` − length, and only then is the ceiling applied.
- R7: The balance is two's-complement signed and may go below zero. It saturates at the most negative value of a `CREDIT_W`-bit integer rather than wrapping.
- R8: `add_en_o` is registered. It becomes 0 one edge after `credit_o` is below `lo_limit_i` (signed), and it becomes 1 one edge after `credit_o` is at or above it.
- R9: A balance exactly equal to `lo_limit_i` keeps `add_en_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rate_i | input | RATE_W | Replenish increment per cycle, 8 fractional bits |
| pkt_valid_i | input | 1 | A packet is committed to the stage buffer this cycle |
| pkt_len_i | input | LEN_W | Length in bytes of the committed packet |
| pkt_transit_i | input | 1 | Packet source: 1 = transit, 0 = local add (charge unaffected) |
| lo_limit_i | input | CREDIT_W | Signed low limit below which adds are stopped |
| add_en_o | output | 1 | Local low-priority add traffic permitted |
| credit_o | output | CREDIT_W | Signed current balance in whole bytes |

## Verification
On every cycle, the assertions check three things: the balance never exceeds the ceiling, an idle cycle never lowers it, and a charge with zero rate lowers it by exactly the packet length. They also check that each edge of `add_en_o` follows a low-limit crossing one cycle earlier. The bench scenarios are needed to show the fractional floor behaviour and the combined charge-plus-replenish arithmetic. They also cover the equality boundary at the low limit, identical charging for transit and added packets, and negative saturation followed by recovery.

// File: rtl/shaper_pkg.sv
package shaper_pkg;
  // saturate an extended-width fixed-point value into [lo, hi]
  function automatic logic signed [63:0] clip64(input logic signed [63:0] v,
                                                input logic signed [63:0] lo,
                                                input logic signed [63:0] hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction
endpackage

// File: rtl/shaper_charge.sv
module shaper_charge #(
  parameter int LEN_W  = 14,
  parameter int FRAC_W = 8,
  parameter int EXT_W  = 30
) (
  input  logic                    pkt_valid_i,
  input  logic [LEN_W-1:0]        pkt_len_i,
  output logic signed [EXT_W-1:0] charge_o
);
  localparam int PAD_W = EXT_W - LEN_W - FRAC_W;

  // transit or added: same charge, source is not an input here
  always_comb begin
    charge_o = '0;
    if (pkt_valid_i) charge_o = $signed({{PAD_W{1'b0}}, pkt_len_i, {FRAC_W{1'b0}}});
  end
endmodule

// File: rtl/shaper_credit_acc.sv
module shaper_credit_acc
  import shaper_pkg::*;
#(
  parameter int CREDIT_W   = 20,
  parameter int FRAC_W     = 8,
  parameter int RATE_W     = 16,
  parameter int EXT_W      = 30,
  parameter int MAX_CREDIT = 2000
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [RATE_W-1:0]          rate_i,
  input  logic signed [EXT_W-1:0]    charge_i,
  output logic signed [CREDIT_W-1:0] credit_o
);
  localparam int ACC_W = CREDIT_W + FRAC_W;
  localparam logic signed [EXT_W-1:0] MAX_FX = $signed(EXT_W'(MAX_CREDIT)) <<< FRAC_W;
  localparam logic signed [EXT_W-1:0] MIN_FX =
    $signed({{(EXT_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}});
  localparam logic signed [ACC_W-1:0] RST_FX = ACC_W'(MAX_FX);

  logic signed [ACC_W-1:0] acc_q;
  logic signed [EXT_W-1:0] sum;
  logic signed [EXT_W-1:0] acc_nxt;

  always_comb begin
    sum     = EXT_W'(acc_q) + $signed({{(EXT_W-RATE_W){1'b0}}, rate_i}) - charge_i;
    acc_nxt = EXT_W'(clip64(64'(sum), 64'(MIN_FX), 64'(MAX_FX)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= RST_FX;
    else         acc_q <= ACC_W'(acc_nxt);
  end

  // floor to whole bytes
  assign credit_o = acc_q[ACC_W-1:FRAC_W];

  AST_CEILING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    credit_o <= CREDIT_W'(MAX_CREDIT)); // R3
  AST_IDLE_NO_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (charge_i == '0) |=> (credit_o >= $past(credit_o))); // R2
  AST_EXACT_CHARGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rate_i == '0) && (charge_i != '0) && (EXT_W'(acc_q) - charge_i > MIN_FX))
    |=> (EXT_W'(credit_o) == EXT_W'($past(credit_o)) - ($past(charge_i) >>> FRAC_W))); // R4
endmodule

// File: rtl/shaper_add_gate.sv
module shaper_add_gate #(
  parameter int CREDIT_W = 20
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic signed [CREDIT_W-1:0] credit_i,
  input  logic signed [CREDIT_W-1:0] lo_limit_i,
  output logic                       add_en_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b1;
    else         en_q <= (credit_i >= lo_limit_i);
  end

  assign add_en_o = en_q;

  AST_STOP_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(add_en_o) |-> ($past(credit_i) < $past(lo_limit_i))); // R8
  AST_RESUME_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(add_en_o) |-> ($past(credit_i) >= $past(lo_limit_i))); // R9
endmodule

// File: rtl/add_credit_shaper.sv
module add_credit_shaper #(
  parameter int CREDIT_W   = 20,
  parameter int FRAC_W     = 8,
  parameter int RATE_W     = 16,
  parameter int LEN_W      = 14,
  parameter int MAX_CREDIT = 2000
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [RATE_W-1:0]          rate_i,
  input  logic                       pkt_valid_i,
  input  logic [LEN_W-1:0]           pkt_len_i,
  input  logic                       pkt_transit_i,
  input  logic signed [CREDIT_W-1:0] lo_limit_i,
  output logic                       add_en_o,
  output logic signed [CREDIT_W-1:0] credit_o
);
  localparam int ACC_W = CREDIT_W + FRAC_W;
  localparam int EXT_W = ACC_W + 2;

  logic signed [EXT_W-1:0] charge;
  logic                    unused_src;

  assign unused_src = pkt_transit_i; // R5: source does not alter the charge

  shaper_charge #(.LEN_W(LEN_W), .FRAC_W(FRAC_W), .EXT_W(EXT_W)) u_charge (
    .pkt_valid_i(pkt_valid_i),
    .pkt_len_i  (pkt_len_i),
    .charge_o   (charge)
  );

  shaper_credit_acc #(
    .CREDIT_W(CREDIT_W), .FRAC_W(FRAC_W), .RATE_W(RATE_W),
    .EXT_W(EXT_W), .MAX_CREDIT(MAX_CREDIT)
  ) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rate_i  (rate_i),
    .charge_i(charge),
    .credit_o(credit_o)
  );

  shaper_add_gate #(.CREDIT_W(CREDIT_W)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .credit_i  (credit_o),
    .lo_limit_i(lo_limit_i),
    .add_en_o  (add_en_o)
  );
endmodule

// File: tb/sim_add_credit_shaper.sv
module sim_add_credit_shaper;
  localparam int CW = 20, FW = 8, RW = 16, LW = 14, MAXC = 2000;
  localparam longint MAX_FX = longint'(MAXC) * 256;
  localparam longint MIN_FX = -(longint'(1) << (CW + FW - 1));

  logic clk = 0, rst_n = 0;
  logic [RW-1:0] rate = '0;
  logic pv = 0, ptr = 0;
  logic [LW-1:0] plen = '0;
  logic signed [CW-1:0] lo = '0;
  logic en;
  logic signed [CW-1:0] cred;

  always #5 clk = ~clk;

  add_credit_shaper u0 (
    .clk_i(clk), .rst_ni(rst_n), .rate_i(rate), .pkt_valid_i(pv),
    .pkt_len_i(plen), .pkt_transit_i(ptr), .lo_limit_i(lo),
    .add_en_o(en), .credit_o(cred)
  );

  typedef struct { longint c; logic e; string tag; } item_t;
  item_t sb[$];
  int n_chk = 0, n_fail = 0;
  longint acc_m = MAX_FX;

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one cycle, update model, push expectation
  task automatic step(input int r, input bit v, input int len, input bit tr,
                      input int lim, input string tag);
    longint prev_c;
    item_t it;
    rate = RW'(r); pv = v; plen = LW'(len); ptr = tr; lo = CW'(lim);
    prev_c = acc_m >>> 8;
    acc_m = acc_m + r - (v ? longint'(len) * 256 : 0);
    if (acc_m > MAX_FX) acc_m = MAX_FX;
    if (acc_m < MIN_FX) acc_m = MIN_FX;
    @(posedge clk);
    it.c = acc_m >>> 8; it.e = (prev_c >= lim); it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check({it.tag, " credit"}, longint'(cred), it.c);
      check({it.tag, " add_en"}, longint'(en), longint'(it.e));
    end
  end

  initial begin
    #(200000 * 10);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    lo = -1000;
    repeat (3) @(negedge clk);
    check("R1 credit in reset", longint'(cred), MAXC);
    check("R1 add_en in reset", longint'(en), 1);
    rst_n = 1;
    @(negedge clk);
    check("R1 credit after release", longint'(cred), MAXC);
    check("R1 add_en after release", longint'(en), 1);
    // R3 ceiling under replenish
    for (int i = 0; i < 4; i++) step('h180, 0, 0, 0, 0, "R3");
    // R4/R5 transit charge then equal-length added charge
    step(0, 1, 700, 1, 0, "R5 transit");
    step(0, 1, 700, 0, 0, "R5 added");
    // R2 fractional replenish: 0.75 byte per cycle
    for (int i = 0; i < 6; i++) step('h0C0, 0, 0, 0, 0, "R2");
    // R6 combined charge and replenish, going negative (R7)
    step('h180, 1, 800, 0, 0, "R6");
    step('h180, 1, 200, 1, 0, "R7 negative");
    step(0, 0, 0, 0, 0, "R8 stop");
    // R8/R9 recover to exactly the limit
    lo = 0;
    while (acc_m < 0) step('h100, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, "R9 equal");
    step(0, 0, 0, 0, 0, "R9 hold");
    step(0, 0, 0, 0, 3, "R8 raise limit");
    step(0, 0, 0, 0, 3, "R8 low");
    // R7 negative saturation
    for (int i = 0; i < 40; i++) step(0, 1, 16383, i[0], -5, "R7 floor");
    step('hFFFF, 1, 1, 0, -5, "R6 at floor");
    // recovery back to ceiling
    for (int i = 0; i < 2200; i++) step('hFFFF, 0, 0, 0, -5, "R3 recover");
    step(0, 0, 0, 0, -5, "R3 end");
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule